// File: doc/BRIEF.md
# ATA PIO Strobe Timing Generator

This block runs one programmed-I/O data transfer on a parallel ATA bus. A controller pulses a start request with a direction flag. The block then drives the read or the write strobe low for an active phase, releases it for a recovery phase, and signals completion with a one-cycle done pulse. Each phase lasts its count plus one system clock. The two counts come from one of two places. When the override enable is set, they come from a timing byte: the upper nibble holds the active count and the lower nibble holds the recovery count. Otherwise they come from a built-in table indexed by PIO mode.

At start the block latches the phase lengths, the direction and the write data, so changes to the configuration inputs during a transfer have no effect on it. A device can stretch the active phase by holding its ready line low. On a read, the bus word is captured on the clock edge where the strobe deasserts and is then held on a registered output. On a write, the bus driver is enabled from the first active cycle through the last recovery cycle.

Top module: `ata_pio_strobe`

## Requirements
- R1: After a synchronous reset the block is idle: both strobes high, busy low, done low, bus enable low, write data output zero and read data output zero.
- R2: With ready high, the selected strobe stays low for exactly (active count + 1) clocks, starting the cycle after start is accepted. The read strobe is used when the direction flag is 0 and the write strobe when it is 1. The two strobes are never low together.
- R3: The recovery phase lasts (recovery count + 1) clocks with both strobes high and busy high. Done is high for exactly one cycle, the cycle right after the last recovery cycle, and busy is already low in that cycle.
- R4: When the override enable is 1, the active count is timing byte bits 7:4 and the recovery count is bits 3:0, with all 16 values of each nibble honoured.
- R5: When the override enable is 0, the counts come from the mode table. Active counts for modes 0, 1, 2, 3, 4 are 5, 3, 3, 2, 2 and recovery counts are 12, 7, 3, 2, 0. Mode values 5 to 7 use the mode 4 entry.
- R6: A start pulse is accepted only while idle. A start during an active or recovery phase is ignored and does not begin a second transfer.
- R7: While ready is low during the active phase, the strobe stays low and the active count does not advance. Each such clock lengthens the active phase by one clock.
- R8: On a read, the read data output takes the bus input value sampled at the edge where the strobe returns high. It keeps that value until the next read captures again, and writes leave it unchanged.
- R9: On a write, the bus enable is high and the write data output equals the data latched at start from the first active cycle through the last recovery cycle. At all other times the enable is low and the write data output is zero.
- R10: Timing byte, override enable, mode, direction and write data are latched when start is accepted. Changing them mid-transfer does not alter the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Transfer request, accepted only when idle |
| write_dir | input | 1 | Transfer direction: 1 write, 0 read |
| timing_byte | input | 8 | Programmed counts: bits 7:4 active, bits 3:0 recovery |
| timing_override | input | 1 | Selects the timing byte instead of the mode table |
| pio_mode | input | 3 | Mode index into the default table |
| wr_data | input | 16 | Word to write |
| iordy | input | 1 | Device ready; low stretches the active phase |
| dd_in | input | 16 | Bus data from the device |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| dd_out | output | 16 | Bus data to the device |
| dd_oe | output | 1 | Bus output enable |
| rd_data | output | 16 | Captured read word |
| busy | output | 1 | High during the active and recovery phases |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong phase or counter value in this block is visible at the strobe pins in the same cycle. A strobe edge that comes one clock early or late, or a recovery phase of the wrong length, moves the done pulse and the busy edge on the very next clock. A wrong latched direction or data word shows up as the wrong strobe, enable or bus value in the first active cycle. A wrong capture instant shows up as a different read word on the cycle after the strobe rises, because the bus input changes every clock. A reference model that advances on every clock and is compared on every clock therefore catches each of these faults within one cycle of where it first appears.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

    localparam int NIB_W     = 4;
    localparam int MODE_W    = 3;
    localparam int DATA_W    = 16;
    localparam int NUM_MODES = 5;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ACTIVE  = 2'd1,
        PH_RECOVER = 2'd2
    } phase_e;

    // Default active-phase counts per mode; modes past the table use the last entry.
    function automatic logic [NIB_W-1:0] mode_active(input int unsigned idx);
        case (idx)
            0:       mode_active = NIB_W'(5);
            1:       mode_active = NIB_W'(3);
            2:       mode_active = NIB_W'(3);
            3:       mode_active = NIB_W'(2);
            default: mode_active = NIB_W'(2);
        endcase
    endfunction

    // Default recovery-phase counts per mode.
    function automatic logic [NIB_W-1:0] mode_recover(input int unsigned idx);
        case (idx)
            0:       mode_recover = NIB_W'(12);
            1:       mode_recover = NIB_W'(7);
            2:       mode_recover = NIB_W'(3);
            3:       mode_recover = NIB_W'(2);
            default: mode_recover = NIB_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/ata_pio_timing_sel.sv
module ata_pio_timing_sel
    import ata_pio_pkg::*;
#(
    parameter int NW    = NIB_W,
    parameter int MW    = MODE_W,
    parameter int MODES = NUM_MODES
) (
    input  logic [2*NW-1:0] timing_byte,
    input  logic            timing_override,
    input  logic [MW-1:0]   pio_mode,
    output logic [NW-1:0]   active_cnt,
    output logic [NW-1:0]   recover_cnt
);
    localparam int LAST = MODES - 1;

    logic [NW-1:0] tbl_act [MODES];
    logic [NW-1:0] tbl_rec [MODES];

    for (genvar g = 0; g < MODES; g++) begin : g_tbl
        assign tbl_act[g] = NW'(mode_active(g));
        assign tbl_rec[g] = NW'(mode_recover(g));
    end

    logic [MW-1:0] mode_idx;

    always_comb begin
        if (int'(pio_mode) > LAST) mode_idx = MW'(LAST);
        else                      mode_idx = pio_mode;

        if (timing_override) begin
            active_cnt  = timing_byte[2*NW-1:NW];
            recover_cnt = timing_byte[NW-1:0];
        end else begin
            active_cnt  = tbl_act[mode_idx];
            recover_cnt = tbl_rec[mode_idx];
        end
    end
endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
    import ata_pio_pkg::*;
#(
    parameter int NW = NIB_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          write_dir,
    input  logic [NW-1:0] active_cnt,
    input  logic [NW-1:0] recover_cnt,
    input  logic          iordy,
    output phase_e        phase,
    output logic          wr_q,
    output logic          accept,
    output logic          capture,
    output logic          done
);
    typedef struct packed {
        phase_e        phase;
        logic [NW-1:0] cnt;
        logic [NW-1:0] act;
        logic [NW-1:0] rec;
        logic          wr;
        logic          done;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        accept   = 1'b0;
        capture  = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    accept    = 1'b1;
                    s_d.phase = PH_ACTIVE;
                    s_d.cnt   = '0;
                    s_d.act   = active_cnt;
                    s_d.rec   = recover_cnt;
                    s_d.wr    = write_dir;
                end
            end
            PH_ACTIVE: begin
                if (iordy) begin
                    if (s_q.cnt == s_q.act) begin
                        s_d.phase = PH_RECOVER;
                        s_d.cnt   = '0;
                        capture   = !s_q.wr;
                    end else begin
                        s_d.cnt = s_q.cnt + NW'(1);
                    end
                end
            end
            PH_RECOVER: begin
                if (s_q.cnt == s_q.rec) begin
                    s_d.phase = PH_IDLE;
                    s_d.cnt   = '0;
                    s_d.done  = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + NW'(1);
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.phase <= PH_IDLE;
            s_q.cnt   <= '0;
            s_q.act   <= '0;
            s_q.rec   <= '0;
            s_q.wr    <= 1'b0;
            s_q.done  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase = s_q.phase;
    assign wr_q  = s_q.wr;
    assign done  = s_q.done;
endmodule

// File: rtl/ata_pio_data.sv
module ata_pio_data
    import ata_pio_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          capture,
    input  phase_e        phase,
    input  logic          wr_q,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] dd_in,
    output logic [DW-1:0] dd_out,
    output logic          dd_oe,
    output logic [DW-1:0] rd_data
);
    typedef struct packed {
        logic [DW-1:0] wdat;
        logic [DW-1:0] rdat;
    } dat_t;

    dat_t d_d, d_q;

    always_comb begin
        d_d = d_q;
        if (accept)  d_d.wdat = wr_data;
        if (capture) d_d.rdat = dd_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            d_q.wdat <= '0;
            d_q.rdat <= '0;
        end else begin
            d_q <= d_d;
        end
    end

    assign dd_oe   = wr_q && (phase != PH_IDLE);
    assign dd_out  = dd_oe ? d_q.wdat : '0;
    assign rd_data = d_q.rdat;
endmodule

// File: rtl/ata_pio_strobe.sv
module ata_pio_strobe
    import ata_pio_pkg::*;
#(
    parameter int NW = NIB_W,
    parameter int MW = MODE_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          write_dir,
    input  logic [2*NW-1:0] timing_byte,
    input  logic          timing_override,
    input  logic [MW-1:0] pio_mode,
    input  logic [DW-1:0] wr_data,
    input  logic          iordy,
    input  logic [DW-1:0] dd_in,
    output logic          dior_n,
    output logic          diow_n,
    output logic [DW-1:0] dd_out,
    output logic          dd_oe,
    output logic [DW-1:0] rd_data,
    output logic          busy,
    output logic          done
);
    logic [NW-1:0] active_cnt;
    logic [NW-1:0] recover_cnt;
    phase_e        phase;
    logic          wr_q;
    logic          accept;
    logic          capture;

    ata_pio_timing_sel #(.NW(NW), .MW(MW), .MODES(NUM_MODES)) u_sel (
        .timing_byte     (timing_byte),
        .timing_override (timing_override),
        .pio_mode        (pio_mode),
        .active_cnt      (active_cnt),
        .recover_cnt     (recover_cnt)
    );

    ata_pio_seq #(.NW(NW)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .write_dir   (write_dir),
        .active_cnt  (active_cnt),
        .recover_cnt (recover_cnt),
        .iordy       (iordy),
        .phase       (phase),
        .wr_q        (wr_q),
        .accept      (accept),
        .capture     (capture),
        .done        (done)
    );

    ata_pio_data #(.DW(DW)) u_dat (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .capture (capture),
        .phase   (phase),
        .wr_q    (wr_q),
        .wr_data (wr_data),
        .dd_in   (dd_in),
        .dd_out  (dd_out),
        .dd_oe   (dd_oe),
        .rd_data (rd_data)
    );

    assign dior_n = !((phase == PH_ACTIVE) && !wr_q);
    assign diow_n = !((phase == PH_ACTIVE) &&  wr_q);
    assign busy   = (phase != PH_IDLE);
endmodule

// File: rtl/ata_pio_strobe_chk.sv
module ata_pio_strobe_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          iordy,
    input logic          dior_n,
    input logic          diow_n,
    input logic          dd_oe,
    input logic [DW-1:0] dd_out,
    input logic [DW-1:0] rd_data,
    input logic          busy,
    input logic          done
);
    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(!dior_n && !diow_n));

    assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    assert_start_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !(dior_n && diow_n)) |=> busy);

    assert_ready_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!(dior_n && diow_n) && !iordy) |=> !(dior_n && diow_n));

    assert_rd_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(dior_n && !$past(dior_n)) |-> $stable(rd_data));

    assert_oe_write_R9: assert property (@(posedge clk) disable iff (rst)
        dd_oe |-> (dior_n && busy));

    assert_out_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !dd_oe |-> (dd_out == '0));
endmodule

bind ata_pio_strobe ata_pio_strobe_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .iordy   (iordy),
    .dior_n  (dior_n),
    .diow_n  (diow_n),
    .dd_oe   (dd_oe),
    .dd_out  (dd_out),
    .rd_data (rd_data),
    .busy    (busy),
    .done    (done)
);

// File: tb/ata_pio_strobe_test.sv
module ata_pio_strobe_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        write_dir = 1'b0;
    logic [7:0]  timing_byte = 8'h00;
    logic        timing_override = 1'b0;
    logic [2:0]  pio_mode = 3'd0;
    logic [15:0] wr_data = 16'h0000;
    logic        iordy = 1'b1;
    logic [15:0] dd_in = 16'h1234;
    logic        dior_n, diow_n, dd_oe, busy, done;
    logic [15:0] dd_out, rd_data;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    // default table held by the bench (R5)
    int tbl_a [5] = '{5, 3, 3, 2, 2};
    int tbl_r [5] = '{12, 7, 3, 2, 0};

    always #5 clk = ~clk;

    ata_pio_strobe uut (
        .clk(clk), .rst(rst), .start(start), .write_dir(write_dir),
        .timing_byte(timing_byte), .timing_override(timing_override),
        .pio_mode(pio_mode), .wr_data(wr_data), .iordy(iordy), .dd_in(dd_in),
        .dior_n(dior_n), .diow_n(diow_n), .dd_out(dd_out), .dd_oe(dd_oe),
        .rd_data(rd_data), .busy(busy), .done(done)
    );

    // behavioural reference: phase number plus remaining-count countdowns
    int          m_ph = 0;
    int          m_rem_a = 0, m_rem_r = 0;
    bit          m_wr = 0, m_done = 0;
    logic [15:0] m_wd = 0, m_rd = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_done = 0; m_rd = 0; m_wd = 0; m_wr = 0;
        end else begin
            m_done = 0;
            if (m_ph == 0) begin
                if (start) begin
                    if (timing_override) begin
                        m_rem_a = int'(timing_byte[7:4]);
                        m_rem_r = int'(timing_byte[3:0]);
                    end else begin
                        m_rem_a = tbl_a[(pio_mode > 4) ? 4 : int'(pio_mode)];
                        m_rem_r = tbl_r[(pio_mode > 4) ? 4 : int'(pio_mode)];
                    end
                    m_wr = write_dir; m_wd = wr_data; m_ph = 1;
                end
            end else if (m_ph == 1) begin
                if (iordy) begin
                    if (m_rem_a == 0) begin
                        m_ph = 2;
                        if (!m_wr) m_rd = dd_in;
                    end else m_rem_a--;
                end
            end else begin
                if (m_rem_r == 0) begin m_ph = 0; m_done = 1; end
                else m_rem_r--;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
        if (!rst) begin
            bit eoe;
            eoe = (m_ph != 0) && m_wr;
            chk("R2", "dior_n", int'(dior_n), int'(!(m_ph == 1 && !m_wr)));
            chk("R2", "diow_n", int'(diow_n), int'(!(m_ph == 1 && m_wr)));
            chk("R3", "busy",   int'(busy),   int'(m_ph != 0));
            chk("R3", "done",   int'(done),   int'(m_done));
            chk("R9", "dd_oe",  int'(dd_oe),  int'(eoe));
            chk("R9", "dd_out", int'(dd_out), int'(eoe ? m_wd : 16'h0));
            chk("R8", "rd_data", int'(rd_data), int'(m_rd));
        end
        dd_in <= dd_in + 16'h0F1D;
    end

    // one transfer; measures strobe-low and recovery lengths at the ports
    task automatic xfer(input bit wr, input logic [2:0] mode, input bit ovr,
                        input logic [7:0] tb, input logic [15:0] wd,
                        input int stall, input bit poke, input string req);
        int ea, er, lowc, recc, n, st;
        if (ovr) begin ea = int'(tb[7:4]); er = int'(tb[3:0]); end
        else begin
            ea = tbl_a[(mode > 4) ? 4 : int'(mode)];
            er = tbl_r[(mode > 4) ? 4 : int'(mode)];
        end
        @(negedge clk);
        start = 1; write_dir = wr; pio_mode = mode; timing_override = ovr;
        timing_byte = tb; wr_data = wd;
        @(negedge clk);
        start = 0;
        // R10: scramble the configuration once the transfer is under way
        write_dir = ~wr; timing_byte = ~tb; pio_mode = mode ^ 3'd3;
        timing_override = ~ovr; wr_data = ~wd;
        iordy = (stall == 0); st = stall;
        lowc = 0; recc = 0; n = 0;
        while (!done && n < 200) begin
            if (!dior_n || !diow_n) lowc++;
            else if (busy) recc++;
            @(negedge clk); n++;
            if (st > 0) begin st--; if (st == 0) iordy = 1; end
            if (poke) begin start = (n == 1 || n == ea + 3); end  // R6 pokes
        end
        start = 0; iordy = 1;
        chk(req, "active clocks (R2/R7)", lowc, ea + 1 + stall);
        chk(req, "recovery clocks (R3)", recc, er + 1);
        chk(req, "done seen (R3)", int'(done), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "dior_n", int'(dior_n), 1);
        chk("R1", "diow_n", int'(diow_n), 1);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "done", int'(done), 0);
        chk("R1", "dd_oe", int'(dd_oe), 0);
        chk("R1", "dd_out", int'(dd_out), 0);
        chk("R1", "rd_data", int'(rd_data), 0);
        rst = 0;
        // R5: every mode, default table, reads then writes
        for (int m = 0; m < 8; m++) xfer(1'b0, 3'(m), 1'b0, 8'hA5, 16'h0, 0, 1'b0, "R5");
        for (int m = 0; m < 5; m++) xfer(1'b1, 3'(m), 1'b0, 8'h00, 16'hC3A0 + 16'(m), 0, 1'b0, "R5");
        // R4: override extremes and mixes
        xfer(1'b0, 3'd0, 1'b1, 8'h00, 16'h0, 0, 1'b0, "R4");
        xfer(1'b1, 3'd4, 1'b1, 8'hF0, 16'hBEEF, 0, 1'b0, "R4");
        xfer(1'b0, 3'd4, 1'b1, 8'h0F, 16'h0, 0, 1'b0, "R4");
        xfer(1'b1, 3'd2, 1'b1, 8'h37, 16'h5A5A, 0, 1'b0, "R4");
        xfer(1'b0, 3'd1, 1'b1, 8'hFF, 16'h0, 0, 1'b0, "R4");
        // R7: ready held low at the start of the active phase
        xfer(1'b0, 3'd4, 1'b0, 8'h00, 16'h0, 4, 1'b0, "R7");
        xfer(1'b1, 3'd0, 1'b1, 8'h21, 16'h1357, 7, 1'b0, "R7");
        // R6: start pulses while busy are ignored
        xfer(1'b0, 3'd0, 1'b0, 8'h00, 16'h0, 0, 1'b1, "R6");
        xfer(1'b1, 3'd3, 1'b1, 8'h43, 16'h2468, 2, 1'b1, "R6");
        // R6: no transfer may have begun after the poked transfer completes
        @(negedge clk);
        chk("R6", "busy after poked transfer", int'(busy), 0);
        // R8: write leaves previously captured read data untouched (per-cycle model)
        xfer(1'b0, 3'd2, 1'b0, 8'h00, 16'h0, 0, 1'b0, "R8");
        xfer(1'b1, 3'd2, 1'b0, 8'h00, 16'hFFFF, 0, 1'b0, "R8");
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule